// File: doc/BRIEF.md
# CAN Field-Aware Bit Error Checker

This block checks the bit a CAN or CAN FD node sends against the bit it reads back from the bus. The check runs once per bit, on a strobe that marks the sample point. A mismatch produces a bit error pulse one clock later. In some frame fields another node may legally override the bus, so the checker masks its comparison there. An external protocol controller tells the checker which field is active through a one-hot field vector. It also supplies the node's role (transmitter or receiver) and a flag that is high while the node drives a dominant acknowledge.

The block holds no frame sequencing of its own. It combines the field vector and the two role inputs into a single enable for the check. It then compares the two bits at the strobe and registers the result. A node-enable input blocks all reporting while the node is off.

Top module: `can_bit_err_chk`

## Requirements
- R1: A synchronous active-high reset clears `bit_err` to 0. While `node_en` is 0, `bit_err` stays 0 whatever the other inputs are.
- R2: Recessive is logic 1 and dominant is logic 0. A comparison happens only in a cycle where `sample_stb` is 1. When the check is enabled and `tx_bit` differs from `rx_bit`, `bit_err` is 1 for exactly the clock after that strobe edge. In every other case `bit_err` is 0.
- R3: When no bit of `field_oh` is set, or only bit 13 (any other frame bit) is set, the check is enabled.
- R4: Start of frame (field bit 0) and CRC delimiter (field bit 1) mask the check, whatever the values of `is_tx` and `ack_drive`.
- R5: In the ACK slot (field bit 2), the check is enabled only when `is_tx` is 0 and `ack_drive` is 1. This is a receiver driving a dominant acknowledge, and sampling recessive there is an error. Every other combination masks the check.
- R6: The FD secondary ACK slot (bit 3), the ACK delimiter (bit 4), end of frame (bit 5) and intermission (bit 6) mask the check.
- R7: The waits for the first recessive bit after an error flag (bit 8) or an overload flag (bit 11) mask the check, so sampling dominant there gives no error. The error delimiter (bit 9) and overload delimiter (bit 12) also mask it.
- R8: The active error flag (bit 7) and active overload flag (bit 10) keep the check enabled, so sampling recessive while driving dominant there is an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| node_en | input | 1 | Node enabled; 0 blocks all errors |
| sample_stb | input | 1 | Sample point strobe, one cycle per bit |
| tx_bit | input | 1 | Bit driven by the node (1 = recessive) |
| rx_bit | input | 1 | Bit sampled from the bus (1 = recessive) |
| field_oh | input | FIELD_W | One-hot active field indicator |
| is_tx | input | 1 | 1 when the node is transmitter |
| ack_drive | input | 1 | 1 while the node drives a dominant ACK |
| bit_err | output | 1 | Bit error pulse, one cycle |

## Verification
The bench uses the default `FIELD_W` of 14, so every field position from the start of frame up to the generic frame bit can be reached. Random stimulus picks one field bit or none, together with random role, ACK drive, strobe and node-enable values. This covers each field combined with both roles and both bit polarities. Directed cases add the four role and drive combinations in the ACK slot, reset applied during a mismatch, and strobe-free cycles.

// File: rtl/cbe_pkg.sv
package cbe_pkg;

  // Bit positions of the one-hot field indicator
  localparam int unsigned FLD_SOF       = 0;
  localparam int unsigned FLD_CRC_DLM   = 1;
  localparam int unsigned FLD_ACK       = 2;
  localparam int unsigned FLD_ACK2      = 3;
  localparam int unsigned FLD_ACK_DLM   = 4;
  localparam int unsigned FLD_EOF       = 5;
  localparam int unsigned FLD_IFS       = 6;
  localparam int unsigned FLD_ERR_FLAG  = 7;
  localparam int unsigned FLD_ERR_WAIT  = 8;
  localparam int unsigned FLD_ERR_DLM   = 9;
  localparam int unsigned FLD_OVL_FLAG  = 10;
  localparam int unsigned FLD_OVL_WAIT  = 11;
  localparam int unsigned FLD_OVL_DLM   = 12;
  localparam int unsigned FLD_BODY      = 13;
  localparam int unsigned FLD_COUNT     = 14;

  localparam logic BUS_RECESSIVE = 1'b1;
  localparam logic BUS_DOMINANT  = 1'b0;

  // Kind of masking that applies to a field position
  typedef enum logic [1:0] {
    MK_NEVER  = 2'd0,   // check stays enabled
    MK_ALWAYS = 2'd1,   // check always masked
    MK_ACK    = 2'd2    // masked unless receiver drives dominant ACK
  } mask_kind_t;

  function automatic mask_kind_t field_mask_kind(input int unsigned idx);
    mask_kind_t k;
    case (idx)
      FLD_SOF, FLD_CRC_DLM, FLD_ACK2, FLD_ACK_DLM, FLD_EOF, FLD_IFS,
      FLD_ERR_WAIT, FLD_ERR_DLM, FLD_OVL_WAIT, FLD_OVL_DLM: k = MK_ALWAYS;
      FLD_ACK:                                              k = MK_ACK;
      default:                                              k = MK_NEVER;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/cbe_field_mask.sv
module cbe_field_mask
  import cbe_pkg::*;
#(
  parameter int unsigned FIELD_W = FLD_COUNT
) (
  input  logic [FIELD_W-1:0] field_oh,
  input  logic               is_tx,
  input  logic               ack_drive,
  output logic               check_en
);

  // A receiver that drives dominant in the ACK slot still checks its bit
  logic ack_keeps_check;
  assign ack_keeps_check = ack_drive & ~is_tx;

  logic [FIELD_W-1:0] mask_if_active;

  for (genvar i = 0; i < FIELD_W; i++) begin : g_fld
    localparam mask_kind_t KIND = field_mask_kind(i);
    if (KIND == MK_ALWAYS) begin : g_always
      assign mask_if_active[i] = 1'b1;
    end else if (KIND == MK_ACK) begin : g_ack
      assign mask_if_active[i] = ~ack_keeps_check;
    end else begin : g_never
      assign mask_if_active[i] = 1'b0;
    end
  end

  assign check_en = ~|(field_oh & mask_if_active);

  always_comb begin
    AST_FIELD_ONEHOT: assert ($onehot0(field_oh) || $isunknown(field_oh)); // R3
  end

endmodule

// File: rtl/cbe_cmp_pulse.sv
module cbe_cmp_pulse
  import cbe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic node_en,
  input  logic sample_stb,
  input  logic tx_bit,
  input  logic rx_bit,
  input  logic check_en,
  output logic bit_err
);

  logic mismatch;
  assign mismatch = (tx_bit != rx_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_err <= 1'b0;
    end else begin
      bit_err <= node_en & sample_stb & check_en & mismatch;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !bit_err); // R1

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !node_en |=> !bit_err); // R1

  AST_NO_STB_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> !bit_err); // R2

  AST_MATCH_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (tx_bit == rx_bit) |=> !bit_err); // R2

  AST_MASKED_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    !check_en |=> !bit_err); // R4

endmodule

// File: rtl/can_bit_err_chk.sv
module can_bit_err_chk
  import cbe_pkg::*;
#(
  parameter int unsigned FIELD_W = FLD_COUNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               node_en,
  input  logic               sample_stb,
  input  logic               tx_bit,
  input  logic               rx_bit,
  input  logic [FIELD_W-1:0] field_oh,
  input  logic               is_tx,
  input  logic               ack_drive,
  output logic               bit_err
);

  logic check_en;

  cbe_field_mask #(.FIELD_W(FIELD_W)) u_mask (
    .field_oh  (field_oh),
    .is_tx     (is_tx),
    .ack_drive (ack_drive),
    .check_en  (check_en)
  );

  cbe_cmp_pulse u_cmp (
    .clk        (clk),
    .rst        (rst),
    .node_en    (node_en),
    .sample_stb (sample_stb),
    .tx_bit     (tx_bit),
    .rx_bit     (rx_bit),
    .check_en   (check_en),
    .bit_err    (bit_err)
  );

  AST_ACTIVE_FLAG_CHECKED: assert property (@(posedge clk) disable iff (rst)
    (node_en && sample_stb && (tx_bit != rx_bit) &&
     (field_oh == FIELD_W'(1) << FLD_ERR_FLAG)) |=> bit_err); // R8

  AST_ACK_RX_CHECKED: assert property (@(posedge clk) disable iff (rst)
    (node_en && sample_stb && (tx_bit != rx_bit) && !is_tx && ack_drive &&
     (field_oh == FIELD_W'(1) << FLD_ACK)) |=> bit_err); // R5

  AST_ACK_TX_MASKED: assert property (@(posedge clk) disable iff (rst)
    (is_tx && (field_oh == FIELD_W'(1) << FLD_ACK)) |=> !bit_err); // R5

  AST_WAIT_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((field_oh == FIELD_W'(1) << FLD_ERR_WAIT) ||
     (field_oh == FIELD_W'(1) << FLD_OVL_WAIT)) |=> !bit_err); // R7

endmodule

// File: tb/can_bit_err_chk_test.sv
module can_bit_err_chk_test;
  import cbe_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int FW = FLD_COUNT;

  logic          clk = 1'b0;
  logic          rst;
  logic          node_en, sample_stb, tx_bit, rx_bit, is_tx, ack_drive;
  logic [FW-1:0] field_oh;
  logic          bit_err;

  int n_checks = 0;
  int n_bad    = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bit_err_chk #(.FIELD_W(FW)) uut (
    .clk(clk), .rst(rst), .node_en(node_en), .sample_stb(sample_stb),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .field_oh(field_oh),
    .is_tx(is_tx), .ack_drive(ack_drive), .bit_err(bit_err)
  );

  // Expected enable computed from the field rules in the requirements
  function automatic bit exp_enabled(input logic [FW-1:0] f, input bit tx, input bit ack);
    if (f == '0)                                  return 1'b1;        // R3
    if (f[13] || f[7] || f[10])                   return 1'b1;        // R3 R8
    if (f[2])                                     return (!tx && ack); // R5
    return 1'b0;                                                      // R4 R6 R7
  endfunction

  function automatic bit exp_err(input bit en, input bit stb, input bit t, input bit r,
                                 input logic [FW-1:0] f, input bit tx, input bit ack);
    return en && stb && (t != r) && exp_enabled(f, tx, ack);
  endfunction

  function automatic string tag_of(input logic [FW-1:0] f);
    if (f == '0 || f[13])       return "R3";
    if (f[0] || f[1])           return "R4";
    if (f[2])                   return "R5";
    if (f[3] || f[4] || f[5] || f[6]) return "R6";
    if (f[7] || f[10])          return "R8";
    return "R7";
  endfunction

  task automatic check(input bit exp, input string tag);
    n_checks++;
    if (bit_err !== exp) begin
      n_bad++;
      $display("FAIL %s: bit_err=%b expected=%b", tag, bit_err, exp);
    end
  endtask

  // Drive at negedge, let one posedge register, check at the next negedge
  task automatic apply(input bit en, input bit stb, input bit t, input bit r,
                       input logic [FW-1:0] f, input bit tx, input bit ack, input string tag);
    node_en = en; sample_stb = stb; tx_bit = t; rx_bit = r;
    field_oh = f; is_tx = tx; ack_drive = ack;
    @(negedge clk);
    check(exp_err(en, stb, t, r, f, tx, ack), tag);
  endtask

  function automatic logic [FW-1:0] one_hot(input int idx);
    return FW'(1) << idx;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; node_en = 1'b1; sample_stb = 1'b1; tx_bit = 1'b0; rx_bit = 1'b1;
    field_oh = '0; is_tx = 1'b1; ack_drive = 1'b0;
    @(negedge clk); @(negedge clk);
    check(1'b0, "R1 reset with mismatch present");
    rst = 1'b0;

    // R2 basic mismatch and strobe dependence
    apply(1, 1, 0, 1, '0, 1, 0, "R2 dominant sent recessive read");
    apply(1, 1, 1, 0, '0, 1, 0, "R2 recessive sent dominant read");
    apply(1, 0, 0, 1, '0, 1, 0, "R2 no strobe");
    apply(1, 1, 1, 1, '0, 1, 0, "R2 match");
    // R1 node disabled
    apply(0, 1, 0, 1, '0, 1, 0, "R1 node off");
    // R3 generic frame bit
    apply(1, 1, 0, 1, one_hot(FLD_BODY), 0, 0, "R3 body bit");
    // R4 SOF / CRC delim any role
    apply(1, 1, 1, 0, one_hot(FLD_SOF), 1, 0, "R4 sof tx");
    apply(1, 1, 0, 1, one_hot(FLD_CRC_DLM), 0, 1, "R4 crc delim rx");
    // R5 all four ACK slot combinations
    apply(1, 1, 0, 1, one_hot(FLD_ACK), 0, 1, "R5 rx drives ack, reads recessive");
    apply(1, 1, 1, 0, one_hot(FLD_ACK), 1, 0, "R5 tx reads dominant ack");
    apply(1, 1, 1, 0, one_hot(FLD_ACK), 0, 0, "R5 rx ack forbidden");
    apply(1, 1, 0, 1, one_hot(FLD_ACK), 1, 1, "R5 tx with ack flag");
    // R6
    apply(1, 1, 1, 0, one_hot(FLD_ACK2), 0, 1, "R6 secondary ack");
    apply(1, 1, 1, 0, one_hot(FLD_EOF), 1, 0, "R6 eof");
    // R7
    apply(1, 1, 1, 0, one_hot(FLD_ERR_WAIT), 1, 0, "R7 wait after error flag");
    apply(1, 1, 1, 0, one_hot(FLD_OVL_DLM), 0, 0, "R7 overload delim");
    // R8
    apply(1, 1, 0, 1, one_hot(FLD_ERR_FLAG), 1, 0, "R8 active error flag");
    apply(1, 1, 0, 1, one_hot(FLD_OVL_FLAG), 0, 0, "R8 active overload flag");
    // R2 pulse lasts one cycle after a single strobe
    apply(1, 1, 0, 1, '0, 1, 0, "R2 pulse");
    apply(1, 0, 0, 1, '0, 1, 0, "R2 pulse ends");

    // Constrained random
    for (int k = 0; k < 3000; k++) begin
      int sel;
      logic [FW-1:0] f;
      sel = int'($urandom_range(FW));
      f = (sel == FW) ? '0 : one_hot(sel);
      apply(($urandom_range(7) != 0), ($urandom_range(3) != 0), 1'($urandom_range(1)),
            1'($urandom_range(1)), f, 1'($urandom_range(1)), 1'($urandom_range(1)),
            tag_of(f));
    end

    // R1 reset during a mismatch clears the output
    apply(1, 1, 0, 1, '0, 1, 0, "R2 before reset");
    rst = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 reset mid-run");
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule